// File: doc/BRIEF.md
# Accumulator 8-bit Arithmetic Logic Unit

This block is the combinational datapath core of a small accumulator machine. It takes three operands of equal width: a value from the data bus, the accumulator, and an index register. A 4-bit function code selects one of eleven operations. The block returns a result word, a carry flag and a zero flag. The operations are load, add, subtract, AND, OR, complement, increment, two right shifts, a left shift, and a compare of the index register against the data bus.

The carry flag has its own rule for each operation. It is a carry out on add and a borrow on subtract and compare. It is forced high on complement and takes the bit shifted out on shifts. Where the carry has no meaning, it is driven low. This keeps every output defined, including for the five function codes that select no operation. The enclosing machine registers the outputs and decodes the instructions; this block does neither.

Top module: `alu8_core`

## Requirements
- R1: For every function code, zero_o is 1 exactly when result_o is all zeros, and 0 otherwise.
- R2: Code 0 (load) gives result_o = data_i and carry_o = 0.
- R3: Code 1 (add) gives result_o = (acc_i + data_i) mod 256, with carry_o set to the carry out of bit 7.
- R4: Code 2 (subtract) gives result_o = (acc_i - data_i) mod 256, with carry_o = 1 exactly when acc_i < data_i as unsigned values (borrow).
- R5: Code 3 (AND) gives acc_i & data_i and code 4 (OR) gives acc_i | data_i, bit by bit, both with carry_o = 0.
- R6: Code 5 (complement) gives result_o = ~acc_i with carry_o = 1.
- R7: Code 6 (increment) gives result_o = (acc_i + 1) mod 256 with carry_o = 0, including when acc_i = 0xFF wraps to 0.
- R8: Code 7 (logical right shift) gives result_o = {0, acc_i[7:1]} with carry_o = acc_i[0].
- R9: Code 8 (left shift) gives result_o = {acc_i[6:0], 0} with carry_o = acc_i[7].
- R10: Code 9 (right shift with bit-0 feedback) gives result_o = {acc_i[0], acc_i[7:1]} with carry_o = acc_i[0].
- R11: Code 10 (compare) gives result_o = (idx_i - data_i) mod 256, with carry_o = 1 exactly when idx_i < data_i; the value of acc_i has no effect on the outputs.
- R12: Codes 11 to 15 give result_o = 0 and carry_o = 0, and so zero_o = 1, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | 8 | Operand from the data bus |
| acc_i | input | 8 | Accumulator operand |
| idx_i | input | 8 | Index register operand, used only by compare |
| op_i | input | 4 | Function code, 0 to 10 defined, 11 to 15 idle |
| result_o | output | 8 | Operation result |
| carry_o | output | 1 | Carry, borrow or shifted-out bit |
| zero_o | output | 1 | High when result_o is zero |

## Verification
The block holds no state, so a fault in its internal steering shows at the ports in the same cycle that the function code is applied. An adder held in the wrong mode, or given the wrong left operand, gives a wrong result or an inverted borrow. A wrong shift variant moves bit 7 or the carry. The bench therefore samples every applied code once in the following half cycle. It covers the operand patterns that flip each flag: equal operands, wrap on increment and add, borrow in both directions, and the set and clear values of the shifted-out bit.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int ALU_W  = 8;
    localparam int OP_W   = 4;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD = 4'd0,
        OP_ADD  = 4'd1,
        OP_SUB  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_COM  = 4'd5,
        OP_INC  = 4'd6,
        OP_LSR  = 4'd7,
        OP_LSL  = 4'd8,
        OP_ASR  = 4'd9,
        OP_CPX  = 4'd10
    } op_e;

    typedef enum logic [1:0] {
        LG_PASS = 2'd0,
        LG_AND  = 2'd1,
        LG_OR   = 2'd2,
        LG_NOT  = 2'd3
    } logic_mode_e;

    typedef enum logic [1:0] {
        SH_RIGHT_ZERO = 2'd0,
        SH_LEFT_ZERO  = 2'd1,
        SH_RIGHT_WRAP = 2'd2
    } shift_mode_e;

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] lhs_i,
    input  logic [W-1:0] rhs_i,
    input  logic         sub_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    logic [W:0]   sum_d;
    logic [W-1:0] rhs_eff_d;

    always_comb begin
        rhs_eff_d = sub_i ? ~rhs_i : rhs_i;
        sum_d     = {1'b0, lhs_i} + {1'b0, rhs_eff_d} + {{W{1'b0}}, sub_i};
        res_o     = sum_d[W-1:0];
        c_o       = sub_i ? ~sum_d[W] : sum_d[W];
    end

    always_comb begin
        if (sub_i) begin
            p_borrow_matches_order_r4: assert (c_o == (lhs_i < rhs_i));
        end else begin
            p_carry_on_wrap_r3: assert (c_o == (res_o < lhs_i));
        end
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic_mode_e  mode_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (mode_i)
            LG_AND:  res_o = a_i & b_i;
            LG_OR:   res_o = a_i | b_i;
            LG_NOT:  res_o = ~a_i;
            default: res_o = b_i;
        endcase
    end

    always_comb begin
        if (mode_i == LG_OR) begin
            p_or_covers_both_r5: assert (((res_o & a_i) == a_i) && ((res_o & b_i) == b_i));
        end
        if (mode_i == LG_AND) begin
            p_and_within_both_r5: assert (((res_o | a_i) == a_i) && ((res_o | b_i) == b_i));
        end
    end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  shift_mode_e  mode_i,
    output logic [W-1:0] res_o,
    output logic         c_o
);
    always_comb begin
        case (mode_i)
            SH_LEFT_ZERO: begin
                res_o = {a_i[W-2:0], 1'b0};
                c_o   = a_i[W-1];
            end
            SH_RIGHT_WRAP: begin
                res_o = {a_i[0], a_i[W-1:1]};
                c_o   = a_i[0];
            end
            default: begin
                res_o = {1'b0, a_i[W-1:1]};
                c_o   = a_i[0];
            end
        endcase
    end

    always_comb begin
        if (mode_i != SH_RIGHT_WRAP) begin
            p_bits_conserved_r8: assert (($countones(res_o) + int'(c_o)) == $countones(a_i));
        end else begin
            p_wrap_feeds_top_r10: assert (res_o[W-1] == c_o);
        end
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W  = ALU_W,
    parameter int OW = OP_W
) (
    input  logic [W-1:0]  data_i,
    input  logic [W-1:0]  acc_i,
    input  logic [W-1:0]  idx_i,
    input  logic [OW-1:0] op_i,
    output logic [W-1:0]  result_o,
    output logic          carry_o,
    output logic          zero_o
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         c;
    } alu_out_t;

    op_e          op_d;
    logic [W-1:0] ar_lhs_d, ar_rhs_d, ar_res;
    logic         ar_sub_d, ar_c;
    logic_mode_e  lg_mode_d;
    logic [W-1:0] lg_res;
    shift_mode_e  sh_mode_d;
    logic [W-1:0] sh_res;
    logic         sh_c;
    alu_out_t     out_d;

    always_comb begin
        op_d      = op_e'(op_i);
        ar_lhs_d  = (op_d == OP_CPX) ? idx_i : acc_i;
        ar_rhs_d  = (op_d == OP_INC) ? W'(1) : data_i;
        ar_sub_d  = (op_d == OP_SUB) || (op_d == OP_CPX);
        case (op_d)
            OP_AND:  lg_mode_d = LG_AND;
            OP_OR:   lg_mode_d = LG_OR;
            OP_COM:  lg_mode_d = LG_NOT;
            default: lg_mode_d = LG_PASS;
        endcase
        case (op_d)
            OP_LSL:  sh_mode_d = SH_LEFT_ZERO;
            OP_ASR:  sh_mode_d = SH_RIGHT_WRAP;
            default: sh_mode_d = SH_RIGHT_ZERO;
        endcase
    end

    alu8_arith #(.W(W)) u_arith (
        .lhs_i (ar_lhs_d),
        .rhs_i (ar_rhs_d),
        .sub_i (ar_sub_d),
        .res_o (ar_res),
        .c_o   (ar_c)
    );

    alu8_logic #(.W(W)) u_logic (
        .a_i    (acc_i),
        .b_i    (data_i),
        .mode_i (lg_mode_d),
        .res_o  (lg_res)
    );

    alu8_shift #(.W(W)) u_shift (
        .a_i    (acc_i),
        .mode_i (sh_mode_d),
        .res_o  (sh_res),
        .c_o    (sh_c)
    );

    always_comb begin
        out_d = '0;
        case (op_d)
            OP_LOAD, OP_AND, OP_OR: out_d = '{res: lg_res, c: 1'b0};
            OP_COM:                 out_d = '{res: lg_res, c: 1'b1};
            OP_ADD, OP_SUB, OP_CPX: out_d = '{res: ar_res, c: ar_c};
            OP_INC:                 out_d = '{res: ar_res, c: 1'b0};
            OP_LSR, OP_LSL, OP_ASR: out_d = '{res: sh_res, c: sh_c};
            default:                out_d = '0;
        endcase
    end

    assign result_o = out_d.res;
    assign carry_o  = out_d.c;
    assign zero_o   = ~|out_d.res;

    always_comb begin
        if (op_d == OP_COM) begin
            p_complement_inverts_r6: assert ((lg_res ^ acc_i) == {W{1'b1}});
        end
        if (op_d == OP_LOAD) begin
            p_load_passes_bus_r2: assert (lg_res == data_i);
        end
        if (op_d == OP_INC) begin
            p_increment_steps_r7: assert ((ar_res - acc_i) == W'(1));
        end
    end
endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;
    typedef struct packed {
        logic [3:0] op;
        logic [7:0] r;
        logic       c;
        logic       z;
    } exp_t;

    logic       clk = 1'b0;
    logic [7:0] data_i = '0, acc_i = '0, idx_i = '0;
    logic [3:0] op_i = 4'd15;
    logic [7:0] result_o;
    logic       carry_o, zero_o;

    int   checks = 0;
    int   errors = 0;
    exp_t q[$];
    bit   done = 0;

    always #10 clk = ~clk;

    alu8_core dut (
        .data_i(data_i), .acc_i(acc_i), .idx_i(idx_i), .op_i(op_i),
        .result_o(result_o), .carry_o(carry_o), .zero_o(zero_o)
    );

    function automatic string tag(input logic [3:0] op);
        case (op)
            4'd0: return "R2";  4'd1: return "R3";  4'd2: return "R4";
            4'd3: return "R5";  4'd4: return "R5";  4'd5: return "R6";
            4'd6: return "R7";  4'd7: return "R8";  4'd8: return "R9";
            4'd9: return "R10"; 4'd10: return "R11";
            default: return "R12";
        endcase
    endfunction

    function automatic exp_t model(input logic [3:0] op, input int d, input int a, input int x);
        exp_t e;
        int   v;
        e.op = op;
        e.c  = 1'b0;
        v    = 0;
        case (op)
            4'd0:  v = d;
            4'd1:  begin v = a + d; e.c = (v >= 256); end
            4'd2:  begin v = a - d + 256; e.c = (a < d); end
            4'd3:  v = a & d;
            4'd4:  v = a | d;
            4'd5:  begin v = 255 - a; e.c = 1'b1; end
            4'd6:  v = a + 1;
            4'd7:  begin v = a / 2; e.c = a[0]; end
            4'd8:  begin v = a * 2; e.c = a[7]; end
            4'd9:  begin v = a / 2 + (a % 2) * 128; e.c = a[0]; end
            4'd10: begin v = x - d + 256; e.c = (x < d); end
            default: v = 0;
        endcase
        e.r = 8'(v % 256);
        e.z = (e.r == 8'd0);
        return e;
    endfunction

    task automatic apply(input logic [3:0] op, input logic [7:0] d, input logic [7:0] a, input logic [7:0] x);
        @(negedge clk);
        op_i = op; data_i = d; acc_i = a; idx_i = x;
        q.push_back(model(op, int'(d), int'(a), int'(x)));
    endtask

    // monitor: samples one half cycle after each drive
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (result_o !== e.r || carry_o !== e.c) begin
                    errors++;
                    $display("FAIL %s op=%0d result/carry actual %h/%b expected %h/%b",
                             tag(e.op), e.op, result_o, carry_o, e.r, e.c);
                end
                checks++;
                if (zero_o !== e.z) begin
                    errors++;
                    $display("FAIL R1 op=%0d zero actual %b expected %b", e.op, zero_o, e.z);
                end
            end
        end
    end

    initial begin
        // reset state: idle code 15 with zero operands
        apply(4'd15, 8'h00, 8'h00, 8'h00);
        // R2 load
        apply(4'd0, 8'h5A, 8'hFF, 8'h00);
        apply(4'd0, 8'h00, 8'hFF, 8'hFF);
        // R3 add: carry, no carry, zero result with carry
        apply(4'd1, 8'h01, 8'hFF, 8'h00);
        apply(4'd1, 8'h10, 8'h20, 8'h00);
        apply(4'd1, 8'h80, 8'h80, 8'h00);
        // R4 subtract: equal, borrow, no borrow
        apply(4'd2, 8'h33, 8'h33, 8'h00);
        apply(4'd2, 8'h34, 8'h33, 8'h00);
        apply(4'd2, 8'h01, 8'h80, 8'h00);
        // R5 AND / OR
        apply(4'd3, 8'h0F, 8'hF0, 8'h00);
        apply(4'd3, 8'h3C, 8'hF6, 8'h00);
        apply(4'd4, 8'h00, 8'h00, 8'hFF);
        apply(4'd4, 8'h81, 8'h18, 8'h00);
        // R6 complement
        apply(4'd5, 8'h00, 8'hFF, 8'h00);
        apply(4'd5, 8'hFF, 8'h5A, 8'h00);
        // R7 increment including wrap
        apply(4'd6, 8'hFF, 8'hFF, 8'h00);
        apply(4'd6, 8'h00, 8'h7F, 8'h00);
        // R8 / R9 / R10 shifts with bit 0 and bit 7 set and clear
        apply(4'd7, 8'h00, 8'h01, 8'h00);
        apply(4'd7, 8'h00, 8'hFE, 8'h00);
        apply(4'd8, 8'h00, 8'h80, 8'h00);
        apply(4'd8, 8'h00, 8'h7F, 8'h00);
        apply(4'd9, 8'h00, 8'h01, 8'h00);
        apply(4'd9, 8'h00, 8'hAA, 8'h00);
        // R11 compare: equal, borrow, acc value varies with no effect
        apply(4'd10, 8'h44, 8'h00, 8'h44);
        apply(4'd10, 8'h44, 8'hFF, 8'h44);
        apply(4'd10, 8'h45, 8'h12, 8'h44);
        apply(4'd10, 8'h01, 8'h01, 8'h90);
        // R12 unused codes with nonzero operands
        for (int k = 11; k < 16; k++) apply(4'(k), 8'hFF, 8'hFF, 8'hFF);
        // sweep all codes with varied operands
        for (int n = 0; n < 400; n++)
            apply(4'(n % 16), 8'($urandom), 8'($urandom), 8'($urandom));
        while (q.size() > 0) @(posedge clk);
        @(negedge clk);
        done = 1;
    end

    initial begin
        for (int t = 0; t < 5000 && !done; t++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule